// File: doc/BRIEF.md
# BCD to Seven-Segment Latching Decoder

This block turns a four-bit binary-coded decimal digit into the seven active-high segment drives of a common-cathode numeric display. A stored copy of the digit lets the display keep showing a value after the source bus has moved on. An active-low load control selects the behaviour. While it is low, the stored copy tracks the input on every clock and the segments show the live input at once. While it is high, the stored copy is frozen and the segments show it.

Two active-low overrides act on the segment outputs only. A lamp-check input lights all seven segments. A dark input turns all of them off. The lamp check wins when both are asserted. Neither override touches the stored digit, so the display returns to its earlier content as soon as both are released. Codes above nine are not decimal digits and leave the display dark.

Top module: `seg7_latch_dec`

## Requirements
- R1: A synchronous active-low reset clears the stored digit to 0. With load high and both overrides released after reset, `seg_o` reads 7'h3F.
- R2: `seg_o` bit 0 is segment a (top), bit 1 is b (upper right), bit 2 is c (lower right), bit 3 is d (bottom), bit 4 is e (lower left), bit 5 is f (upper left) and bit 6 is g (middle). Digits 0,1,2,3,4,5,7,8 give 3F,06,5B,4F,66,6D,07,7F.
- R3: While `pass_n_i` is low and both overrides are released, `seg_o` shows the decoded value of the current `code_i` in the same cycle, with no register delay.
- R4: While `pass_n_i` is high, `seg_o` shows the code that was on `code_i` at the last rising clock edge where `pass_n_i` was low. Changes on `code_i` have no effect during this time.
- R5: While `lamp_n_i` is low, `seg_o` is 7'h7F, whatever the other inputs are.
- R6: While `lamp_n_i` is high and `blank_n_i` is low, `seg_o` is 7'h00.
- R7: The overrides never alter the stored digit. The digit is loaded or held by `pass_n_i` alone, and it reappears on `seg_o` once both overrides are released.
- R8: Input codes 10 through 15 drive `seg_o` to 7'h00.
- R9: Digit 6 is drawn without segment a (7'h7C), and digit 9 is drawn without segment d (7'h67).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the digit register |
| rst_n | input | 1 | Synchronous reset, active low |
| code_i | input | DATA_W (4) | BCD digit input |
| pass_n_i | input | 1 | Load control, active low: low = track input, high = hold |
| lamp_n_i | input | 1 | Lamp check, active low: lights all segments |
| blank_n_i | input | 1 | Dark control, active low: turns all segments off |
| seg_o | output | SEG_W (7) | Segment drives a..g, active high |

## Verification
Three things can land in the same cycle: the load control rising, the digit bus changing, and an override being asserted. The bench drives each of these cases. It raises `pass_n_i` in the same cycle that `code_i` moves to a new digit, and expects the older digit to be held. It also lets the register load while lamp check or dark is active, then releases the override and expects the loaded digit to appear. A behavioural model with its own held-code variable and per-segment digit sets is compared with `seg_o` on every clock. Each requirement also has explicit checks.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
   localparam int BCD_W = 4;
   localparam int SEG_N = 7;

   typedef logic [SEG_N-1:0] seg_t;

   typedef enum int {
      SEG_A = 0,
      SEG_B = 1,
      SEG_C = 2,
      SEG_D = 3,
      SEG_E = 4,
      SEG_F = 5,
      SEG_G = 6
   } seg_idx_e;

   localparam seg_t SEG_ALL_ON  = '1;
   localparam seg_t SEG_ALL_OFF = '0;
endpackage

// File: rtl/seg7_code_hold.sv
module seg7_code_hold #(
   parameter int DATA_W      = 4,
   parameter bit TRANSPARENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_n,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] stored,
   output logic [DATA_W-1:0] src
);
   logic [DATA_W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (!load_n)
         q <= d;
   end

   assign stored = q;

   generate
      if (TRANSPARENT) begin : g_pass
         // live input while loading, frozen copy otherwise
         assign src = load_n ? q : d;
      end else begin : g_reg
         assign src = q;
      end
   endgenerate
endmodule

// File: rtl/seg7_glyph.sv
module seg7_glyph
   import seg7_pkg::*;
#(
   parameter int DATA_W = BCD_W
) (
   input  logic [DATA_W-1:0] bcd,
   output seg_t              pat
);
   always_comb begin
      pat = SEG_ALL_OFF;
      unique case (bcd)
         4'd0:    pat = 7'h3F;
         4'd1:    pat = 7'h06;
         4'd2:    pat = 7'h5B;
         4'd3:    pat = 7'h4F;
         4'd4:    pat = 7'h66;
         4'd5:    pat = 7'h6D;
         4'd6:    pat = 7'h7C;   // tail (a) omitted
         4'd7:    pat = 7'h07;
         4'd8:    pat = 7'h7F;
         4'd9:    pat = 7'h67;   // tail (d) omitted
         default: pat = SEG_ALL_OFF;
      endcase
   end
endmodule

// File: rtl/seg7_override.sv
module seg7_override #(
   parameter int SEG_W = 7
) (
   input  logic [SEG_W-1:0] raw,
   input  logic             lamp_n,
   input  logic             blank_n,
   output logic [SEG_W-1:0] seg
);
   genvar i;
   generate
      for (i = 0; i < SEG_W; i++) begin : g_seg
         // lamp check outranks dark
         assign seg[i] = (!lamp_n) | (blank_n & raw[i]);
      end
   endgenerate
endmodule

// File: rtl/seg7_latch_dec.sv
module seg7_latch_dec
   import seg7_pkg::*;
#(
   parameter int DATA_W      = BCD_W,
   parameter int SEG_W       = SEG_N,
   parameter bit TRANSPARENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] code_i,
   input  logic              pass_n_i,
   input  logic              lamp_n_i,
   input  logic              blank_n_i,
   output logic [SEG_W-1:0]  seg_o
);
   localparam int DIGITS = 1 << DATA_W;

   generate
      if (DATA_W != BCD_W) begin : g_bad_data
         $error("seg7_latch_dec: DATA_W must equal %0d", BCD_W);
      end
      if (SEG_W != SEG_N) begin : g_bad_seg
         $error("seg7_latch_dec: SEG_W must equal %0d", SEG_N);
      end
      if (DIGITS < 10) begin : g_bad_range
         $error("seg7_latch_dec: code width cannot hold a decimal digit");
      end
   endgenerate

   logic [DATA_W-1:0] held;
   logic [DATA_W-1:0] shown;
   seg_t              raw;

   seg7_code_hold #(
      .DATA_W      (DATA_W),
      .TRANSPARENT (TRANSPARENT)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (pass_n_i),
      .d      (code_i),
      .stored (held),
      .src    (shown)
   );

   seg7_glyph #(
      .DATA_W (DATA_W)
   ) u_glyph (
      .bcd (shown),
      .pat (raw)
   );

   seg7_override #(
      .SEG_W (SEG_W)
   ) u_ovr (
      .raw     (raw),
      .lamp_n  (lamp_n_i),
      .blank_n (blank_n_i),
      .seg     (seg_o)
   );
endmodule

// File: rtl/seg7_latch_dec_chk.sv
module seg7_latch_dec_chk #(
   parameter int DATA_W = 4,
   parameter int SEG_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] code_i,
   input logic              pass_n_i,
   input logic              lamp_n_i,
   input logic              blank_n_i,
   input logic [SEG_W-1:0]  seg_o,
   input logic [DATA_W-1:0] held
);
   // R5
   lamp_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lamp_n_i |-> seg_o == {SEG_W{1'b1}});

   // R6
   blank_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lamp_n_i && !blank_n_i) |-> seg_o == '0);

   // R8
   invalid_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_n_i && code_i > 4'd9) |-> (seg_o == '0 || !lamp_n_i));

   // R3
   live_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_n_i && lamp_n_i && blank_n_i && code_i == 4'd8) |-> seg_o == {SEG_W{1'b1}});

   // R4
   hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(pass_n_i) && pass_n_i && lamp_n_i && blank_n_i
       && $past(lamp_n_i) && $past(blank_n_i)) |-> $stable(seg_o));

   // R7
   ovr_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_n_i && (!lamp_n_i || !blank_n_i)) |=> $stable(held));
endmodule

bind seg7_latch_dec seg7_latch_dec_chk #(
   .DATA_W (DATA_W),
   .SEG_W  (SEG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .code_i    (code_i),
   .pass_n_i  (pass_n_i),
   .lamp_n_i  (lamp_n_i),
   .blank_n_i (blank_n_i),
   .seg_o     (seg_o),
   .held      (held)
);

// File: tb/sim_seg7_latch_dec.sv
`timescale 1ns/100ps
module sim_seg7_latch_dec;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] code = 4'd5;
   logic       pass_n = 1'b1;
   logic       lamp_n = 1'b1;
   logic       blank_n = 1'b1;
   logic [6:0] seg;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit model_on = 1'b0;
   int m_held = 0;

   always #2.5 clk = ~clk;

   seg7_latch_dec u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .code_i    (code),
      .pass_n_i  (pass_n),
      .lamp_n_i  (lamp_n),
      .blank_n_i (blank_n),
      .seg_o     (seg)
   );

   // segment membership: bit k set => digit k lights that segment
   function automatic logic [6:0] ref_pat(input int c);
      int masks [7] = '{16'h03AD, 16'h039F, 16'h03FB, 16'h016D,
                        16'h0145, 16'h0371, 16'h037C};
      logic [6:0] r;
      for (int s = 0; s < 7; s++) r[s] = masks[s][c];
      return r;
   endfunction

   function automatic logic [6:0] ref_out();
      int src;
      if (!lamp_n) return 7'h7F;
      if (!blank_n) return 7'h00;
      src = pass_n ? m_held : int'(code);
      return ref_pat(src);
   endfunction

   task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: seg=%h expected %h (code=%0d pass_n=%b lamp_n=%b blank_n=%b)",
                  req, act, exp, code, pass_n, lamp_n, blank_n);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // reference register, updated on the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) m_held <= 0;
      else if (!pass_n) m_held <= int'(code);
   end

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (model_on && rst_n) begin
         if (!lamp_n)       chk("R5 model", seg, ref_out());
         else if (!blank_n) chk("R6 model", seg, ref_out());
         else if (!pass_n)  chk("R3 model", seg, ref_out());
         else               chk("R4 model", seg, ref_out());
      end
   end

   task automatic step(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      #1;
   endtask

   task automatic look(input string req, input logic [6:0] exp);
      @(negedge clk);
      chk(req, seg, exp);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      model_on = 1'b1;
      step(1);
      look("R1 reset digit", 7'h3F);

      // sweep all codes through the transparent path
      pass_n = 1'b0;
      for (int c = 0; c < 16; c++) begin
         code = 4'(c);
         #0.5;
         if (c > 9)                 chk("R8 invalid dark", seg, 7'h00);
         else if (c == 6 || c == 9) chk("R9 tail digit", seg, ref_pat(c));
         else                       chk("R2 digit pattern", seg, ref_pat(c));
         step(1);
      end
      code = 4'd2;
      #0.5;
      chk("R3 same-cycle follow", seg, 7'h5B);

      // load 3, then raise pass_n while the bus moves to 7 in the same cycle
      step(1);
      code = 4'd3;
      step(1);
      pass_n = 1'b1;
      code = 4'd7;
      look("R4 edge capture", 7'h4F);
      for (int c = 0; c < 10; c++) begin
         step(1);
         code = 4'(c);
         look("R4 hold vs bus", 7'h4F);
      end

      // four override combinations, held digit 3
      step(1);
      lamp_n = 1'b0; blank_n = 1'b1; look("R5 lamp only", 7'h7F);
      step(1);
      lamp_n = 1'b0; blank_n = 1'b0; look("R5 lamp over dark", 7'h7F);
      step(1);
      lamp_n = 1'b1; blank_n = 1'b0; look("R6 dark only", 7'h00);
      step(1);
      code = 4'd1;
      look("R6 dark with bus change", 7'h00);
      step(1);
      lamp_n = 1'b1; blank_n = 1'b1; look("R7 held digit back", 7'h4F);

      // load while lamp check active, then release
      step(1);
      lamp_n = 1'b0; pass_n = 1'b0; code = 4'd9;
      look("R5 lamp while loading", 7'h7F);
      step(1);
      pass_n = 1'b1; code = 4'd0;
      look("R5 lamp while holding", 7'h7F);
      step(1);
      lamp_n = 1'b1;
      look("R7 loaded under lamp", 7'h67);

      // load under dark, transparent release shows live code
      step(1);
      blank_n = 1'b0; pass_n = 1'b0; code = 4'd4;
      look("R6 dark while loading", 7'h00);
      step(1);
      blank_n = 1'b1;
      look("R7 live after dark", 7'h66);
      step(1);
      code = 4'd12;
      look("R8 invalid live", 7'h00);
      step(1);
      pass_n = 1'b1; code = 4'd8;
      look("R8 invalid held", 7'h00);

      // reset while holding returns stored digit to 0
      step(1);
      rst_n = 1'b0;
      step(1);
      rst_n = 1'b1;
      look("R1 reset clears held", 7'h3F);
      step(2);
      finish_run();
   end
endmodule